// File: doc/BRIEF.md
# Synthesizer Register-Load Sequencer

This block is the master side of a three-wire serial link (serial clock, serial data, load strobe) that programs a frequency synthesizer. It holds no words of its own. The configuration words come in on a flat input bus, one 32-bit slice per register. A start request sends all six words, from the highest register to register 0. Each word goes out most significant bit first. The load strobe is held low for the whole word and is raised after the last bit, which tells the receiver to commit the word. A single-word request sends just one chosen register, framed the same way.

The serial clock idles low. Each bit is presented while the clock is low and is sampled by the receiver on the rising edge. The half-period comes from a divider value that is latched when a request is accepted, so the bit rate is at most half the system clock. The block also registers a chip-enable request onto the synthesizer's power-down pin, independently of any transfer. Once a transfer has completed, it qualifies the lock-detect level before it reports lock.

Top module: `synth_cfg_loader`

## Requirements
- R1: While reset is low and right after it is released: load strobe high, serial clock low, serial data low, busy low, locked low, chip-enable low.
- R2: A full sequence sends word slices 5, 4, 3, 2, 1, 0 in that order. Slice k sits at bits [32k+31:32k] of the word bus. Each word is sent as 32 bits, bit 31 first.
- R3: With half-period H = the divider input (a value of 0 counts as 1), latched at acceptance, each bit is driven for H cycles with the serial clock low and then H cycles with it high. Data does not change while the clock is high.
- R4: The load strobe falls in the first cycle of a word. It stays low for all 32 bits and then for one more half-period with the clock low and the data holding bit 0. It is then high for 2H cycles before the next word starts. Each word slot takes 67H cycles.
- R5: Busy rises in the cycle after a request is accepted. It falls when the last word's 2H high gap ends, which is 67H cycles per word sent.
- R6: A start or single-word request that arrives while busy has no effect on the words sent or on the timing.
- R7: A single-word request with a 3-bit index of 0 to 5 sends only that slice. An index of 6 or 7 is ignored and busy stays low. If start and single-word requests arrive in the same cycle, the full sequence is run.
- R8: Locked is cleared when any request is accepted. After a transfer completes, locked is asserted once lock-detect has been sampled high on 8 consecutive clock edges. A low sample clears it and restarts the count.
- R9: The chip-enable output equals the chip-enable request from one clock earlier, whether or not a transfer is running.
- R10: While idle, the serial data and the serial clock are low and the load strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a full six-word load |
| single_i | input | 1 | Request a single-word load |
| single_idx_i | input | 3 | Slice to send in single-word mode |
| half_div_i | input | 8 | Serial half-period in system cycles (0 counts as 1) |
| cfg_words_i | input | 192 | Six 32-bit configuration words, slice k at [32k+31:32k] |
| ce_req_i | input | 1 | Chip-enable request |
| lock_det_i | input | 1 | Lock-detect level from the synthesizer |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| le_o | output | 1 | Load strobe, low while a word is shifted |
| ce_o | output | 1 | Chip-enable to the synthesizer |
| busy_o | output | 1 | Transfer in progress |
| locked_o | output | 1 | Lock qualified after configuration |

## Verification
The hardest situations to reach are the ones at request boundaries. These include a request that lands mid-transfer, start and single-word requests raised in the same cycle, a single-word index just past the last slice, and a lock-detect level that drops partway through its qualification count. The stimulus places extra start pulses in the middle of a full load, raises both requests together with a zero divider, tries indices 6 and 7 while idle, and breaks the lock-detect run after five high samples. A bench-side receiver rebuilds every word from the rising serial-clock edges and the strobe rises. A behavioural model checks every output on every cycle.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

   // Sequencer occupancy
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // Number of half-periods in one word slot: two per bit, one tail, two gap
   function automatic int slot_halves(input int word_w);
      return 2 * word_w + 3;
   endfunction

endpackage

// File: rtl/scl_half_timer.sv
module scl_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] half_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] sub_q;

   // tick marks the last system cycle of a half-period
   assign tick_o = run_i && (sub_q == (half_i - DIV_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub_q <= '0;
      end else if (restart_i || !run_i || tick_o) begin
         sub_q <= '0;
      end else begin
         sub_q <= sub_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/scl_word_shift.sv
module scl_word_shift #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              tick_i,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              le_o,
   output logic              word_done_o
);

   localparam int TAIL    = 2 * WORD_W;
   localparam int PH_LAST = synth_cfg_pkg::slot_halves(WORD_W) - 1;
   localparam int PH_W    = $clog2(PH_LAST + 1);

   logic [PH_W-1:0]   phase_q;
   logic [WORD_W-1:0] sreg_q;

   assign word_done_o = busy_i && tick_i && (phase_q == PH_W'(PH_LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         sreg_q  <= '0;
      end else if (load_i) begin
         phase_q <= '0;
         sreg_q  <= word_i;
      end else if (busy_i && tick_i) begin
         if (phase_q == PH_W'(PH_LAST)) begin
            phase_q <= '0;
         end else begin
            phase_q <= phase_q + PH_W'(1);
         end
         // advance to the next bit after each high half, except the last bit
         if (phase_q[0] && (phase_q < PH_W'(TAIL - 1))) begin
            sreg_q <= sreg_q << 1;
         end
      end else if (!busy_i) begin
         phase_q <= '0;
      end
   end

   assign le_o    = !busy_i || (phase_q > PH_W'(TAIL));
   assign sclk_o  = busy_i && (phase_q < PH_W'(TAIL)) && phase_q[0];
   assign sdata_o = busy_i && (phase_q <= PH_W'(TAIL)) && sreg_q[WORD_W-1];

endmodule

// File: rtl/scl_seq_ctrl.sv
module scl_seq_ctrl #(
   parameter int NUM_WORDS = 6,
   parameter int IDX_W     = 3,
   parameter int DIV_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             single_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             word_done_i,
   output logic             busy_o,
   output logic             accept_o,
   output logic             finish_o,
   output logic             load_o,
   output logic [IDX_W-1:0] load_idx_o,
   output logic [DIV_W-1:0] half_o
);

   import synth_cfg_pkg::*;

   seq_state_e       state_q;
   logic             single_q;
   logic [IDX_W-1:0] cur_q;
   logic [DIV_W-1:0] half_q;
   logic             last_word;
   logic             idx_ok;

   assign idx_ok    = int'(idx_i) < NUM_WORDS;
   assign busy_o    = (state_q == SEQ_RUN);
   assign accept_o  = !busy_o && (start_i || (single_i && idx_ok));
   assign last_word = single_q || (cur_q == '0);
   assign finish_o  = word_done_i && last_word;
   assign load_o    = accept_o || (word_done_i && !last_word);
   assign half_o    = half_q;

   always_comb begin
      if (accept_o) begin
         load_idx_o = start_i ? IDX_W'(NUM_WORDS - 1) : idx_i;
      end else begin
         load_idx_o = cur_q - IDX_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         single_q <= 1'b0;
         cur_q    <= '0;
         half_q   <= DIV_W'(1);
      end else if (accept_o) begin
         state_q  <= SEQ_RUN;
         single_q <= !start_i;
         cur_q    <= load_idx_o;
         half_q   <= (div_i == '0) ? DIV_W'(1) : div_i;
      end else if (finish_o) begin
         state_q  <= SEQ_IDLE;
      end else if (word_done_i) begin
         cur_q    <= load_idx_o;
      end
   end

endmodule

// File: rtl/scl_lock_qual.sv
module scl_lock_qual #(
   parameter int LOCK_CNT    = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic arm_i,
   input  logic lock_det_i,
   output logic locked_o
);

   localparam int CNT_W = $clog2(LOCK_CNT + 1);

   logic             lock_s;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign lock_s = lock_det_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sync_q <= '0;
         end else begin
            sync_q <= SYNC_STAGES'({sync_q, lock_det_i});
         end
      end
      assign lock_s = sync_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (clear_i) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (arm_i) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (armed_q) begin
         if (!lock_s) begin
            cnt_q <= '0;
         end else if (cnt_q != CNT_W'(LOCK_CNT)) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign locked_o = (cnt_q == CNT_W'(LOCK_CNT));

endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader #(
   parameter int WORD_W      = 32,
   parameter int NUM_WORDS   = 6,
   parameter int IDX_W       = 3,
   parameter int DIV_W       = 8,
   parameter int LOCK_CNT    = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic                          single_i,
   input  logic [IDX_W-1:0]              single_idx_i,
   input  logic [DIV_W-1:0]              half_div_i,
   input  logic [NUM_WORDS*WORD_W-1:0]   cfg_words_i,
   input  logic                          ce_req_i,
   input  logic                          lock_det_i,
   output logic                          sclk_o,
   output logic                          sdata_o,
   output logic                          le_o,
   output logic                          ce_o,
   output logic                          busy_o,
   output logic                          locked_o
);

   // elaboration-time parameter checks
   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (NUM_WORDS < 1 || NUM_WORDS > (1 << IDX_W)) begin : g_bad_num
      $error("NUM_WORDS must fit the index width");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if (LOCK_CNT < 1) begin : g_bad_lock
      $error("LOCK_CNT must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic [WORD_W-1:0] words [NUM_WORDS];
   logic [WORD_W-1:0] word_sel;
   logic              accept, finish, load, tick, word_done;
   logic [IDX_W-1:0]  load_idx;
   logic [DIV_W-1:0]  half;
   logic              ce_q;

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slice
      assign words[g] = cfg_words_i[g*WORD_W +: WORD_W];
   end

   always_comb begin
      word_sel = '0;
      for (int k = 0; k < NUM_WORDS; k++) begin
         if (load_idx == IDX_W'(k)) begin
            word_sel = words[k];
         end
      end
   end

   scl_seq_ctrl #(
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (IDX_W),
      .DIV_W     (DIV_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .single_i    (single_i),
      .idx_i       (single_idx_i),
      .div_i       (half_div_i),
      .word_done_i (word_done),
      .busy_o      (busy_o),
      .accept_o    (accept),
      .finish_o    (finish),
      .load_o      (load),
      .load_idx_o  (load_idx),
      .half_o      (half)
   );

   scl_half_timer #(
      .DIV_W (DIV_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (busy_o),
      .restart_i (load),
      .half_i    (half),
      .tick_o    (tick)
   );

   scl_word_shift #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy_i      (busy_o),
      .load_i      (load),
      .word_i      (word_sel),
      .tick_i      (tick),
      .sclk_o      (sclk_o),
      .sdata_o     (sdata_o),
      .le_o        (le_o),
      .word_done_o (word_done)
   );

   scl_lock_qual #(
      .LOCK_CNT    (LOCK_CNT),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (accept),
      .arm_i      (finish),
      .lock_det_i (lock_det_i),
      .locked_o   (locked_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_q <= 1'b0;
      end else begin
         ce_q <= ce_req_i;
      end
   end
   assign ce_o = ce_q;

endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk #(
   parameter int NUM_WORDS = 6,
   parameter int IDX_W     = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             single_i,
   input logic [IDX_W-1:0] single_idx_i,
   input logic             ce_req_i,
   input logic             sclk_o,
   input logic             sdata_o,
   input logic             le_o,
   input logic             ce_o,
   input logic             busy_o,
   input logic             locked_o
);

   logic past_ok_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         past_ok_q <= 1'b0;
      end else begin
         past_ok_q <= 1'b1;
      end
   end

   assert_idle_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (le_o && !sclk_o && !sdata_o));

   assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok_q && sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

   assert_strobe_clk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (le_o |-> !sclk_o));

   assert_strobe_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok_q && $rose(le_o)) |-> !$past(sclk_o));

   assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   assert_bad_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i && single_i && (int'(single_idx_i) >= NUM_WORDS)) |=> !busy_o);

   assert_locked_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |-> !busy_o);

   assert_locked_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok_q && $rose(locked_o)) |-> $past(!busy_o));

   assert_ce_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok_q |-> (ce_o == $past(ce_req_i)));

endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(
   .NUM_WORDS (NUM_WORDS),
   .IDX_W     (IDX_W)
) u_chk (.*);

// File: tb/synth_cfg_loader_tb.sv
`timescale 1ns/1ps
module synth_cfg_loader_tb;

   localparam int W  = 32;
   localparam int N  = 6;
   localparam int IW = 3;
   localparam int DW = 8;
   localparam int PH_LAST = 2*W + 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            start_i = 1'b0, single_i = 1'b0;
   logic [IW-1:0]   single_idx_i = '0;
   logic [DW-1:0]   half_div_i = '0;
   logic [N*W-1:0]  cfg_words_i;
   logic            ce_req_i = 1'b0, lock_det_i = 1'b0;
   logic            sclk_o, sdata_o, le_o, ce_o, busy_o, locked_o;

   synth_cfg_loader u_dut (.*);

   int n_chk = 0, n_bad = 0;
   bit cmp_en = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int q[$];
   bit m_busy = 0, m_armed = 0, m_ce = 0;
   int m_half = 1, m_sub = 0, m_phase = 0, m_cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); m_busy = 0; m_armed = 0; m_ce = 0;
         m_half = 1; m_sub = 0; m_phase = 0; m_cnt = 0;
      end else begin
         m_ce = ce_req_i;
         if (m_busy) begin
            if (m_sub == m_half - 1) begin
               m_sub = 0;
               if (m_phase == PH_LAST) begin
                  m_phase = 0;
                  void'(q.pop_front());
                  if (q.size() == 0) begin
                     m_busy = 0; m_armed = 1; m_cnt = 0;
                  end
               end else begin
                  m_phase++;
               end
            end else begin
               m_sub++;
            end
         end else begin
            if (m_armed) m_cnt = lock_det_i ? ((m_cnt == 8) ? 8 : m_cnt + 1) : 0;
            if (start_i || (single_i && single_idx_i <= 5)) begin
               q.delete();
               if (start_i) begin
                  for (int k = N-1; k >= 0; k--) q.push_back(k);
               end else begin
                  q.push_back(int'(single_idx_i));
               end
               m_half = (half_div_i == 0) ? 1 : int'(half_div_i);
               m_busy = 1; m_sub = 0; m_phase = 0; m_armed = 0; m_cnt = 0;
            end
         end
      end
   end

   function automatic logic exp_data();
      logic [W-1:0] w;
      int pos;
      if (!m_busy || m_phase > 2*W || q.size() == 0) return 1'b0;
      w   = cfg_words_i[q[0]*W +: W];
      pos = (m_phase == 2*W) ? 0 : (W - 1 - m_phase/2);
      return w[pos];
   endfunction

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R4 le_o",     le_o,     !m_busy || m_phase > 2*W);
         chk("R3 sclk_o",   sclk_o,   m_busy && m_phase < 2*W && (m_phase % 2 == 1));
         chk("R2 sdata_o",  sdata_o,  exp_data());
         chk("R5 busy_o",   busy_o,   m_busy);
         chk("R8 locked_o", locked_o, m_cnt == 8);
         chk("R9 ce_o",     ce_o,     m_ce);
      end
   end

   // ---------------- bench-side receiver ----------------
   logic [W-1:0] rx_sh = '0;
   logic [W-1:0] rx_q[$];
   logic sclk_p = 1'b0, le_p = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk_o && !sclk_p) rx_sh = {rx_sh[W-2:0], sdata_o};
         if (le_o && !le_p) rx_q.push_back(rx_sh);
      end
      sclk_p = sclk_o;
      le_p   = le_o;
   end

   // chip-enable request wanders independently of transfers
   int cyc = 0;
   always @(negedge clk) begin
      cyc++;
      ce_req_i = (cyc % 37) < 20;
   end

   task automatic wait_idle();
      do @(negedge clk); while (busy_o);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R5 watchdog expired busy_o actual=%0d expected=0", busy_o);
      summary();
      $finish;
   end

   initial begin
      for (int k = 0; k < N; k++) cfg_words_i[k*W +: W] = (32'h9E3779B9 * (k + 1)) ^ {8'(k), 24'h5A0C31};

      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 le_o",     le_o,     1);
      chk("R1 sclk_o",   sclk_o,   0);
      chk("R1 sdata_o",  sdata_o,  0);
      chk("R1 busy_o",   busy_o,   0);
      chk("R1 locked_o", locked_o, 0);
      chk("R1 ce_o",     ce_o,     0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_en = 1'b1;

      // full load at H=1, extra start pulses mid-transfer (R6), lock held high
      rx_q.delete();
      half_div_i = 8'd1; lock_det_i = 1'b1;
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      repeat (50) @(negedge clk);
      start_i = 1'b1; single_i = 1'b1; single_idx_i = 3'd3;
      @(negedge clk); start_i = 1'b0; single_i = 1'b0;
      repeat (200) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      wait_idle();
      repeat (12) @(negedge clk);
      chk("R6 word count", rx_q.size(), N);
      for (int k = 0; k < N && k < rx_q.size(); k++)
         chk("R2 word order", rx_q[k], cfg_words_i[(N-1-k)*W +: W]);
      chk("R8 locked after 8 highs", locked_o, 1);

      // single word, H=3, lock-detect drops mid-count
      rx_q.delete();
      half_div_i = 8'd3; single_i = 1'b1; single_idx_i = 3'd2;
      @(negedge clk); single_i = 1'b0; single_idx_i = '0;
      chk("R8 cleared on accept", locked_o, 0);
      wait_idle();
      repeat (5) @(negedge clk);
      lock_det_i = 1'b0; @(negedge clk); lock_det_i = 1'b1;
      repeat (5) @(negedge clk);
      chk("R8 restart after low", locked_o, 0);
      repeat (6) @(negedge clk);
      chk("R8 relock", locked_o, 1);
      chk("R7 single count", rx_q.size(), 1);
      if (rx_q.size() > 0) chk("R7 single word", rx_q[0], cfg_words_i[2*W +: W]);

      // out-of-range indices ignored
      for (int bad = 6; bad < 8; bad++) begin
         single_i = 1'b1; single_idx_i = IW'(bad);
         @(negedge clk); single_i = 1'b0;
         repeat (3) @(negedge clk);
         chk("R7 bad index busy", busy_o, 0);
         chk("R7 bad index le", le_o, 1);
         chk("R7 bad index locked kept", locked_o, 1);
      end

      // both requests at once, zero divider counts as 1
      rx_q.delete();
      half_div_i = 8'd0; start_i = 1'b1; single_i = 1'b1; single_idx_i = 3'd1;
      @(negedge clk); start_i = 1'b0; single_i = 1'b0;
      repeat (N*(PH_LAST+1) - 1) @(negedge clk);
      chk("R5 busy duration end", busy_o, 1);
      @(negedge clk);
      chk("R5 busy cleared", busy_o, 0);
      chk("R7 start wins count", rx_q.size(), N);

      // single word of slice 5 and slice 0 at H=2
      rx_q.delete();
      half_div_i = 8'd2;
      single_i = 1'b1; single_idx_i = 3'd5; @(negedge clk); single_i = 1'b0;
      wait_idle();
      single_i = 1'b1; single_idx_i = 3'd0; @(negedge clk); single_i = 1'b0;
      wait_idle();
      repeat (4) @(negedge clk);
      chk("R7 pair count", rx_q.size(), 2);
      if (rx_q.size() == 2) begin
         chk("R7 slice 5", rx_q[0], cfg_words_i[5*W +: W]);
         chk("R7 slice 0", rx_q[1], cfg_words_i[0 +: W]);
      end
      chk("R10 idle sdata", sdata_o, 0);

      summary();
      $finish;
   end

endmodule